// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

The block generates four independent pulse-width modulated outputs from one system clock. Software reaches it through a plain write/read register bus. One shared control word gates each channel on or off and picks, for each channel, how many system cycles make up one counting step: 1, 8, 64 or 512. Each channel also has its own configuration word holding a period length in steps and a duty count in steps.

A free-running divider shared by all channels produces the three slow step strobes. Each channel counter advances on the strobe its select field names. The output is high for the first duty steps of every period. New period and duty values are held back until the running period ends, so a reconfiguration never cuts a pulse short. Turning a channel off forces its pin low on the next clock and rewinds its counter.

Top module: `mpwm_top`

## Requirements
- R1: After reset all `pwm_out` bits are 0 and every register reads back as 0.
- R2: Word address 0x0 is the control word. Bit n (n = 0..3) enables channel n. Bits 2n+5:2n+4 hold the step select of channel n. Bits 31:12 read 0. Word address 0x4+4n holds channel n's configuration, with bits 15:0 the period in steps and bits 31:16 the duty in steps. It reads back all 32 bits. Any other address, including one whose low two bits are not 0, reads 0 and ignores writes. `bus_rdata` shows the word at the `bus_addr` sampled on the previous clock edge.
- R3: Step select 0, 1, 2 and 3 make one step last 1, 8, 64 and 512 system clock cycles. All channels draw on one shared divider.
- R4: A period lasts exactly as many steps as the period field holds. A period field of 0 means 65536 steps.
- R5: The output is high while the step count within the period is below the duty field. A duty of 0 keeps it low, and a duty at or above the period keeps it high.
- R6: When an enable bit is written to 1 on clock edge E, the channel starts at step 0 on edge E+1. Its output goes high on that edge if the duty is non-zero.
- R7: When an enable bit is written to 0 on edge D, the output is low from edge D+1 on. A later enable starts a fresh period from step 0.
- R8: A configuration write takes effect only at the next period boundary. A write that lands on the same edge as a boundary takes effect at the boundary after that one.
- R9: Channels run independently, each with its own period, duty, select and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A configuration write and a period wrap can land on the same clock edge. The bench finds a rising edge of the output, which marks the wrap edge. It counts forward by the period and times a write so the write lands exactly on the next wrap. The high time of the period that follows must still show the old duty, and the period after that must show the new one. A write landing mid-period is judged the same way: the output must not jump to match the new duty before the boundary.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int DATA_W   = 32;
  localparam int FIELD_W  = 16;
  localparam int NTAP     = 4;
  localparam int SEL_W    = $clog2(NTAP);
  localparam int TAP_LOG  = 3;

  typedef struct packed {
    logic [FIELD_W-1:0] duty;
    logic [FIELD_W-1:0] period;
  } chan_cfg_t;
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NCH*(1+SEL_W)-1:0]    ctrl_o,
  output chan_cfg_t [NCH-1:0]         cfg_o
);
  localparam int CTRL_W = NCH * (1 + SEL_W);
  localparam int WORD_W = AW - 2;

  logic [WORD_W-1:0] widx;
  logic              aligned;
  logic [DATA_W-1:0] rd_mux;

  assign widx    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    rd_mux = '0;
    if (aligned && widx == '0) rd_mux = DATA_W'(ctrl_o);
    for (int n = 0; n < NCH; n++) begin
      if (aligned && widx == WORD_W'(n + 1)) rd_mux = cfg_o[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      cfg_o  <= '0;
      rdata  <= '0;
    end else begin
      if (we && aligned && widx == '0) ctrl_o <= wdata[CTRL_W-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (we && aligned && widx == WORD_W'(n + 1)) cfg_o[n] <= wdata;
      end
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mpwm_prescale.sv
module mpwm_prescale
  import mpwm_pkg::*;
#(
  parameter int TAPS = NTAP,
  parameter int LOGS = TAP_LOG
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TAPS-1:0] tick_o
);
  localparam int PRE_W = LOGS * (TAPS - 1);

  logic [PRE_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + PRE_W'(1);
  end

  assign tick_o[0] = 1'b1;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tick_o[k] = &div_cnt[LOGS*k-1:0];
  end
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
  import mpwm_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          step,
  input  logic [FW-1:0] cfg_period,
  input  logic [FW-1:0] cfg_duty,
  output logic          pwm_o,
  output logic          run_o,
  output logic [FW:0]   cnt_o,
  output logic [FW:0]   per_o
);
  localparam int CNT_W = FW + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << FW;

  logic [FW-1:0]    duty_q, duty_n;
  logic [CNT_W-1:0] cnt_n, per_n, per_eff;
  logic             run_n, pwm_n;

  assign per_eff = (cfg_period == '0) ? FULL : {1'b0, cfg_period};

  always_comb begin
    run_n  = run_o;
    cnt_n  = cnt_o;
    per_n  = per_o;
    duty_n = duty_q;
    if (!en) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else if (!run_o) begin
      run_n  = 1'b1;
      cnt_n  = '0;
      per_n  = per_eff;
      duty_n = cfg_duty;
    end else if (step) begin
      if (cnt_o == per_o - CNT_W'(1)) begin
        cnt_n  = '0;
        per_n  = per_eff;
        duty_n = cfg_duty;
      end else begin
        cnt_n = cnt_o + CNT_W'(1);
      end
    end
    pwm_n = run_n && (cnt_n < {1'b0, duty_n});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o  <= 1'b0;
      cnt_o  <= '0;
      per_o  <= FULL;
      duty_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      run_o  <= run_n;
      cnt_o  <= cnt_n;
      per_o  <= per_n;
      duty_q <= duty_n;
      pwm_o  <= pwm_n;
    end
  end
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
  import mpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int CTRL_W = NCH * (1 + SEL_W);

  logic [CTRL_W-1:0]            ctrl;
  chan_cfg_t [NCH-1:0]          cfg;
  logic [NTAP-1:0]              tick;
  logic [NCH-1:0]               en_vec, step_vec, run_vec;
  logic [NCH-1:0][FIELD_W:0]    cnt_vec, per_vec;

  mpwm_regs #(.NCH(NCH), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .ctrl_o(ctrl), .cfg_o(cfg)
  );

  mpwm_prescale #(.TAPS(NTAP), .LOGS(TAP_LOG)) pre_i (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [SEL_W-1:0] sel;
    assign sel         = ctrl[NCH + SEL_W*n +: SEL_W];
    assign en_vec[n]   = ctrl[n];
    assign step_vec[n] = tick[sel];

    mpwm_chan #(.FW(FIELD_W)) chan_i (
      .clk(clk), .rst(rst), .en(en_vec[n]), .step(step_vec[n]),
      .cfg_period(cfg[n].period), .cfg_duty(cfg[n].duty),
      .pwm_o(pwm_out[n]), .run_o(run_vec[n]),
      .cnt_o(cnt_vec[n]), .per_o(per_vec[n])
    );
  end
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
  import mpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic [AW-1:0]            bus_addr,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NCH-1:0]           en_vec,
  input logic [NCH-1:0]           step_vec,
  input logic [NCH-1:0]           run_vec,
  input logic [NCH-1:0][FIELD_W:0] cnt_vec,
  input logic [NCH-1:0][FIELD_W:0] per_vec,
  input logic [NTAP-1:0]          tick,
  input logic [NCH-1:0]           pwm_out
);
  localparam int CTRL_W = NCH * (1 + SEL_W);

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == '0) |=> (bus_rdata[DATA_W-1:CTRL_W] == '0));

  a_r3_tap_nesting: assert property (@(posedge clk) disable iff (rst)
    tick[NTAP-1] |-> (&tick));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
      !en_vec[n] |=> !pwm_out[n]);

    a_r4_count_in_period: assert property (@(posedge clk) disable iff (rst)
      run_vec[n] |-> (cnt_vec[n] < per_vec[n]));

    a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
      (run_vec[n] && en_vec[n] && !step_vec[n]) |=> $stable(pwm_out[n]));
  end
endmodule

bind mpwm_top mpwm_checker #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .en_vec(en_vec), .step_vec(step_vec), .run_vec(run_vec),
  .cnt_vec(cnt_vec), .per_vec(per_vec), .tick(tick), .pwm_out(pwm_out)
);

// File: tb/mpwm_top_tb_top.sv
`timescale 1ns/1ps
module mpwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ctrl_sh = '0;

  always #10 clk = ~clk;

  mpwm_top dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step1();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step1();
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    step1();
    d = bus_rdata;
  endtask

  task automatic set_cfg(input int ch, input int per, input int duty);
    bus_write(6'(4 + 4*ch), {duty[15:0], per[15:0]});
  endtask

  task automatic set_ctrl(input int ch, input bit en, input int sel);
    ctrl_sh[ch] = en;
    ctrl_sh[4 + 2*ch +: 2] = sel[1:0];
    bus_write(6'h0, ctrl_sh);
  endtask

  task automatic wait_rise(input int ch, input int limit, output int waited);
    logic prev;
    prev = pwm_out[ch];
    waited = 0;
    while (waited < limit) begin
      step1();
      waited++;
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
  endtask

  task automatic high_run(input int ch, output int n);
    n = 1;
    for (int i = 0; i < 100000; i++) begin
      step1();
      if (pwm_out[ch]) n++;
      else break;
    end
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    repeat (cycles) begin
      step1();
      if (pwm_out[ch]) n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwm_out == 4'b0, "R1", "outputs after reset", pwm_out, 0);
    bus_read(6'h00, d);
    chk(d == 0, "R1", "control after reset", d, 0);
    bus_read(6'h10, d);
    chk(d == 0, "R1", "channel 3 config after reset", d, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    for (int n = 0; n < 4; n++) bus_write(6'(4 + 4*n), 32'hA5A5_1230 + 32'(n));
    for (int n = 0; n < 4; n++) begin
      bus_read(6'(4 + 4*n), d);
      chk(d == 32'hA5A5_1230 + 32'(n), "R2", "config readback", d, 32'hA5A5_1230 + n);
    end
    bus_write(6'h00, 32'hFFFF_FFFF);
    bus_read(6'h00, d);
    chk(d == 32'h0000_0FFF, "R2", "control unused bits zero", d, 32'hFFF);
    bus_write(6'h00, 32'h0);
    bus_write(6'h14, 32'hDEAD_BEEF);
    bus_write(6'h05, 32'h1111_1111);
    bus_read(6'h14, d);
    chk(d == 0, "R2", "unmapped word reads zero", d, 0);
    bus_read(6'h05, d);
    chk(d == 0, "R2", "misaligned address reads zero", d, 0);
    bus_read(6'h04, d);
    chk(d == 32'hA5A5_1230, "R2", "misaligned write ignored", d, 32'hA5A5_1230);
  endtask

  task automatic t_basic();
    int n;
    set_cfg(0, 10, 3);
    set_ctrl(0, 1'b1, 0);
    step1();
    chk(pwm_out[0] == 1'b1, "R6", "output high one edge after enable", pwm_out[0], 1);
    high_run(0, n);
    chk(n == 3, "R5", "high run duty 3", n, 3);
    wait_rise(0, 100, n);
    wait_rise(0, 100, n);
    chk(n == 10, "R4", "period 10 steps", n, 10);
  endtask

  task automatic t_shadow();
    int n;
    wait_rise(0, 100, n);
    repeat (4) step1();
    set_cfg(0, 10, 7);
    chk(pwm_out[0] == 1'b0, "R8", "mid-period write not applied early", pwm_out[0], 0);
    wait_rise(0, 100, n);
    chk(n == 5, "R8", "boundary after mid write", n, 5);
    high_run(0, n);
    chk(n == 7, "R8", "new duty after boundary", n, 7);
    repeat (2) step1();
    set_cfg(0, 10, 2);
    chk(pwm_out[0] == 1'b1, "R8", "wrap on write edge", pwm_out[0], 1);
    high_run(0, n);
    chk(n == 7, "R8", "write on boundary keeps old duty", n, 7);
    wait_rise(0, 100, n);
    high_run(0, n);
    chk(n == 2, "R8", "write on boundary applied one period later", n, 2);
  endtask

  task automatic t_disable();
    int n;
    wait_rise(0, 100, n);
    set_ctrl(0, 1'b0, 0);
    step1();
    chk(pwm_out[0] == 1'b0, "R7", "low after disable", pwm_out[0], 0);
    count_high(0, 20, n);
    chk(n == 0, "R7", "stays low while disabled", n, 0);
    set_ctrl(0, 1'b1, 0);
    step1();
    high_run(0, n);
    chk(n == 2, "R7", "re-enable starts fresh period", n, 2);
    set_ctrl(0, 1'b0, 0);
  endtask

  task automatic t_duty_edges();
    int n;
    set_cfg(1, 5, 0);
    set_ctrl(1, 1'b1, 0);
    step1();
    count_high(1, 20, n);
    chk(n == 0, "R5", "duty 0 always low", n, 0);
    set_cfg(1, 5, 3);
    repeat (6) step1();
    count_high(1, 20, n);
    chk(n == 12, "R5", "duty 3 of 5 over 20 cycles", n, 12);
    set_cfg(1, 5, 9);
    repeat (6) step1();
    count_high(1, 20, n);
    chk(n == 20, "R5", "duty above period always high", n, 20);
    set_cfg(1, 5, 5);
    repeat (6) step1();
    count_high(1, 20, n);
    chk(n == 20, "R5", "duty equal period always high", n, 20);
    set_ctrl(1, 1'b0, 0);
  endtask

  task automatic t_prescale(input int sel, input int per, input int duty,
                            input int exp_per, input int exp_hi);
    int n;
    set_ctrl(2, 1'b0, 0);
    set_cfg(2, per, duty);
    set_ctrl(2, 1'b1, sel);
    wait_rise(2, 5000, n);
    wait_rise(2, 5000, n);
    wait_rise(2, 5000, n);
    chk(n == exp_per, "R3", $sformatf("period cycles sel %0d", sel), n, exp_per);
    high_run(2, n);
    chk(n == exp_hi, "R3", $sformatf("high cycles sel %0d", sel), n, exp_hi);
  endtask

  task automatic t_independent();
    int h0, h2, h3;
    set_ctrl(2, 1'b0, 0);
    set_cfg(0, 10, 3);
    set_cfg(3, 6, 2);
    set_ctrl(0, 1'b1, 0);
    set_ctrl(3, 1'b1, 0);
    repeat (3) step1();
    h0 = 0; h2 = 0; h3 = 0;
    repeat (60) begin
      step1();
      if (pwm_out[0]) h0++;
      if (pwm_out[2]) h2++;
      if (pwm_out[3]) h3++;
    end
    chk(h0 == 18, "R9", "channel 0 high count", h0, 18);
    chk(h3 == 20, "R9", "channel 3 high count", h3, 20);
    chk(h2 == 0, "R9", "disabled channel 2 low", h2, 0);
    set_ctrl(0, 1'b0, 0);
    set_ctrl(3, 1'b0, 0);
  endtask

  task automatic t_zero_period();
    int n;
    set_cfg(1, 0, 1);
    set_ctrl(1, 1'b1, 0);
    wait_rise(1, 10, n);
    wait_rise(1, 70000, n);
    chk(n == 65536, "R4", "period field 0 gives 65536 steps", n, 65536);
    set_ctrl(1, 1'b0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=190000 expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step1();
    t_reset();
    t_regmap();
    t_basic();
    t_shadow();
    t_disable();
    t_duty_edges();
    t_prescale(1, 4, 2, 32, 16);
    t_prescale(2, 2, 1, 128, 64);
    t_prescale(3, 2, 1, 1024, 512);
    t_independent();
    t_zero_period();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule